// File: doc/BRIEF.md
# Sized Shift and Rotate Unit with Condition Flags

The block shifts or rotates one operand of byte, word or long size and produces the result together with a fresh set of condition flags: extend (X), negative (N), zero (Z), overflow (V) and carry (C). It offers arithmetic and logical shifts in both directions, plain rotates in both directions, and rotates that pass through the extend bit as one more bit of the ring. The shift count is a 6-bit unsigned value. A separate request pin selects the single-bit form used for memory operands, which always shifts by one at word size. An X-update qualifier marks the cases that write a new extend bit, so the flag file can leave X alone otherwise.

The datapath itself is purely combinational. It sits behind one output register so that results line up with a clock. Requests form a valid-only stream. Every cycle with `in_valid` high is accepted, and its result appears with `out_valid` high on the following cycle. There is no ready signal. A consumer therefore cannot apply back-pressure and must take each result in the cycle it is presented. The output register holds its contents until the next accepted request.

At byte and word size only the low 8 or 16 bits of the result are computed. The bits above them are copied from the operand unchanged, so a caller can write the full register back.

Top module: `srf_unit`

## Requirements
- R1: Operation codes on `in_op` are 0 arithmetic left, 1 logical left, 2 arithmetic right, 3 logical right, 4 rotate left, 5 rotate right, 6 rotate left through X, and 7 rotate right through X. Size codes on `in_size` are 0 byte (8 bits), 1 word (16 bits), and 2 or 3 long (32 bits). The count is the 6-bit unsigned value on `in_count` (0 to 63).
- R2: A shift (codes 0 to 3) with a count of zero returns the operand unchanged, clears C and V, leaves X unchanged and keeps `out_x_upd` low.
- R3: A left shift with a nonzero count places the last bit shifted out of the top in C and X. When the count is at least the operand size, the sized result is zero and C and X are both cleared.
- R4: An arithmetic left shift sets V when the top bit of the sized result differs from the top bit of the operand. A logical left shift always clears V.
- R5: A right shift with a nonzero count places the last bit shifted out of the bottom in C and X. Vacated bits are filled with the sign bit (arithmetic) or with zero (logical). A count of at least the size gives pure sign fill or pure zero. A count above the size gives C and X equal to the sign bit (arithmetic) or to 0 (logical). All right shifts clear V.
- R6: Plain rotates use the count modulo the size. A reduced count of zero returns the operand and clears C. Otherwise rotate left takes C from result bit 0, and rotate right takes C from the result's top bit. X is never changed (`out_x_upd` low).
- R7: Rotates through X use the count modulo (size+1) on a ring made of the operand with X beyond its top bit. The last bit passed through X becomes both C and the new X. A reduced count of zero returns the operand, copies X into C, leaves X unchanged and keeps `out_x_upd` low.
- R8: Every operation sets N from the top bit of the sized result and Z when the sized result is zero. All rotates clear V.
- R9: At byte and word size, the result bits above the operand size equal the corresponding operand bits.
- R10: With `in_mem1` high, the operation runs with a count of one at word size, whatever `in_count` and `in_size` hold.
- R11: After reset, `out_valid` is low and all outputs are zero. A request accepted with `in_valid` high produces its result with `out_valid` high on the next clock edge. A cycle without `in_valid` drops `out_valid` and holds the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 3 | Operation code (R1) |
| in_size | input | 2 | Operand size code (R1) |
| in_count | input | 6 | Shift or rotate count |
| in_mem1 | input | 1 | Single-bit word form, count forced to one |
| in_data | input | 32 | Operand |
| in_x | input | 1 | Incoming extend flag |
| out_valid | output | 1 | Result present |
| out_data | output | 32 | Result, upper bits passed through at small sizes |
| out_x | output | 1 | New extend flag (equals incoming X when not updated) |
| out_x_upd | output | 1 | Extend flag is written by this result |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry flag |

## Verification
On every cycle, the assertions check the properties that do not depend on the exact data value. These are the one-cycle valid timing, the zero-count shift rule, V being clear for logical left shifts and for all rotates, X being untouched by plain rotates, the all-zero result of over-long left shifts at long size, the pass-through of upper bits at byte size and in the single-bit form, and the agreement of Z with a long result. The exact placement of bits, the carry taken from the last bit shifted out, the modulo reduction of rotate counts, and the behaviour of the X ring can only be shown by the bench's scenarios. These compare every output against expected values worked out one bit step at a time, over counts on both sides of 8, 9, 16, 17, 32 and 33 for each size.

// File: rtl/srf_pkg.sv
package srf_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ASL = 3'd0,
    OP_LSL = 3'd1,
    OP_ASR = 3'd2,
    OP_LSR = 3'd3,
    OP_ROL = 3'd4,
    OP_ROR = 3'd5,
    OP_RXL = 3'd6,
    OP_RXR = 3'd7
  } srf_op_e;

  typedef struct packed {
    logic x;
    logic x_upd;
    logic n;
    logic z;
    logic v;
    logic c;
  } srf_flags_t;

endpackage

// File: rtl/srf_lane.sv
// One operand size: shifts, rotates and X-ring rotates on W bits.
module srf_lane
  import srf_pkg::*;
#(
  parameter int W      = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input  srf_op_e             op,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [DATA_W-1:0]   d_full,
  input  logic                x_in,
  output logic [DATA_W-1:0]   res_full,
  output srf_flags_t          fl
);

  localparam int                 LW     = $clog2(W);
  localparam logic [CNT_W-1:0]   W_C    = CNT_W'(W);
  localparam logic [CNT_W-1:0]   RING_C = CNT_W'(W + 1);
  localparam logic [LW:0]        W_L    = (LW + 1)'(W);
  localparam logic [DATA_W-1:0]  MASK   = DATA_W'({W{1'b1}});

  logic [W-1:0]     d;
  logic [CNT_W-1:0] k_sh;
  logic             fill;
  logic [W:0]       sh_l;
  logic [W+1:0]     sh_r;
  logic             unused_sh_top;
  logic [LW-1:0]    r_amt;
  logic [W-1:0]     rot_l, rot_r;
  logic [CNT_W-1:0] m_rx;
  logic [W:0]       ring, rx_l, rx_r;
  logic [W-1:0]     r;
  logic             c, v, xu;

  assign d    = d_full[W-1:0];
  assign k_sh = (cnt > W_C) ? W_C : cnt;
  assign fill = (op == OP_ASR) & d[W-1];

  // left: bit W holds the last bit pushed out of the top
  assign sh_l = {1'b0, d} << k_sh;
  // right: bit 0 holds the last bit pushed out of the bottom
  assign sh_r          = $signed({fill, d, 1'b0}) >>> k_sh;
  assign unused_sh_top = sh_r[W+1];

  assign r_amt = cnt[LW-1:0];
  assign rot_l = (d << r_amt) | (d >> (W_L - {1'b0, r_amt}));
  assign rot_r = (d >> r_amt) | (d << (W_L - {1'b0, r_amt}));

  assign m_rx = cnt % RING_C;
  assign ring = {x_in, d};
  assign rx_l = (ring << m_rx) | (ring >> (RING_C - m_rx));
  assign rx_r = (ring >> m_rx) | (ring << (RING_C - m_rx));

  always_comb begin
    r  = d;
    c  = 1'b0;
    v  = 1'b0;
    xu = 1'b0;
    unique case (op)
      OP_ASL, OP_LSL: begin
        if (cnt != '0) begin
          r  = sh_l[W-1:0];
          c  = (cnt < W_C) & sh_l[W];
          xu = 1'b1;
          v  = (op == OP_ASL) & (r[W-1] ^ d[W-1]);
        end
      end
      OP_ASR, OP_LSR: begin
        if (cnt != '0) begin
          r  = sh_r[W:1];
          c  = (cnt > W_C) ? fill : sh_r[0];
          xu = 1'b1;
        end
      end
      OP_ROL: begin
        r = rot_l;
        c = (r_amt != '0) & rot_l[0];
      end
      OP_ROR: begin
        r = rot_r;
        c = (r_amt != '0) & rot_r[W-1];
      end
      OP_RXL, OP_RXR: begin
        r  = (op == OP_RXL) ? rx_l[W-1:0] : rx_r[W-1:0];
        xu = (m_rx != '0);
        c  = xu ? ((op == OP_RXL) ? rx_l[W] : rx_r[W]) : x_in;
      end
      default: ;
    endcase
  end

  assign fl.x     = xu ? c : x_in;
  assign fl.x_upd = xu;
  assign fl.n     = r[W-1];
  assign fl.z     = (r == '0);
  assign fl.v     = v;
  assign fl.c     = c;

  assign res_full = (d_full & ~MASK) | DATA_W'(r);

endmodule

// File: rtl/srf_core.sv
// One lane per operand size; the decoded size picks the lane.
module srf_core
  import srf_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NSIZE  = 3,
  parameter int CNT_W  = 6,
  parameter int SIZE_W = 2,
  localparam int DATA_W = BYTE_W << (NSIZE - 1)
) (
  input  srf_op_e             op,
  input  logic [SIZE_W-1:0]   size,
  input  logic [CNT_W-1:0]    count,
  input  logic                mem1,
  input  logic [DATA_W-1:0]   data,
  input  logic                x_in,
  output logic [DATA_W-1:0]   res,
  output srf_flags_t          fl
);

  localparam int                IDX_W    = (NSIZE > 1) ? $clog2(NSIZE) : 1;
  localparam logic [SIZE_W-1:0] LAST_SZ  = SIZE_W'(NSIZE - 1);
  localparam logic [SIZE_W-1:0] WORD_SZ  = SIZE_W'(1);
  localparam logic [CNT_W-1:0]  ONE_CNT  = CNT_W'(1);

  logic [SIZE_W-1:0] eff_size;
  logic [CNT_W-1:0]  eff_cnt;
  logic [IDX_W-1:0]  sel;
  logic [DATA_W-1:0] lane_res [NSIZE];
  srf_flags_t        lane_fl  [NSIZE];

  assign eff_size = mem1 ? WORD_SZ : ((size > LAST_SZ) ? LAST_SZ : size);
  assign eff_cnt  = mem1 ? ONE_CNT : count;
  assign sel      = IDX_W'(eff_size);

  for (genvar gi = 0; gi < NSIZE; gi++) begin : g_lane
    srf_lane #(
      .W      (BYTE_W << gi),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W)
    ) u_lane (
      .op       (op),
      .cnt      (eff_cnt),
      .d_full   (data),
      .x_in     (x_in),
      .res_full (lane_res[gi]),
      .fl       (lane_fl[gi])
    );
  end

  assign res = lane_res[sel];
  assign fl  = lane_fl[sel];

endmodule

// File: rtl/srf_unit.sv
// Registered shift/rotate unit: valid-only request stream, one-cycle result.
module srf_unit
  import srf_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NSIZE  = 3,
  parameter int CNT_W  = 6,
  parameter int SIZE_W = 2,
  localparam int DATA_W = BYTE_W << (NSIZE - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  logic [SIZE_W-1:0] in_size,
  input  logic [CNT_W-1:0]  in_count,
  input  logic              in_mem1,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_x,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_x,
  output logic              out_x_upd,
  output logic              out_n,
  output logic              out_z,
  output logic              out_v,
  output logic              out_c
);

  logic [DATA_W-1:0] nx_res;
  srf_flags_t        nx_fl;
  logic [DATA_W-1:0] q_res;
  srf_flags_t        q_fl;
  logic              q_vld;

  srf_core #(
    .BYTE_W (BYTE_W),
    .NSIZE  (NSIZE),
    .CNT_W  (CNT_W),
    .SIZE_W (SIZE_W)
  ) u_core (
    .op    (srf_op_e'(in_op)),
    .size  (in_size),
    .count (in_count),
    .mem1  (in_mem1),
    .data  (in_data),
    .x_in  (in_x),
    .res   (nx_res),
    .fl    (nx_fl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_vld <= 1'b0;
      q_res <= '0;
      q_fl  <= '0;
    end else begin
      q_vld <= in_valid;
      if (in_valid) begin
        q_res <= nx_res;
        q_fl  <= nx_fl;
      end
    end
  end

  assign out_valid = q_vld;
  assign out_data  = q_res;
  assign out_x     = q_fl.x;
  assign out_x_upd = q_fl.x_upd;
  assign out_n     = q_fl.n;
  assign out_z     = q_fl.z;
  assign out_v     = q_fl.v;
  assign out_c     = q_fl.c;

endmodule

// File: rtl/srf_unit_chk.sv
module srf_unit_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6,
  parameter int SIZE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        in_op,
  input logic [SIZE_W-1:0] in_size,
  input logic [CNT_W-1:0]  in_count,
  input logic              in_mem1,
  input logic [DATA_W-1:0] in_data,
  input logic              in_x,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_x,
  input logic              out_x_upd,
  input logic              out_z,
  input logic              out_v,
  input logic              out_c
);

  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DATA_W);

  p_valid_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_zero_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_mem1 && in_op < 3'd4 && in_count == '0) |=>
      (!out_c && !out_v && !out_x_upd && out_data == $past(in_data) && out_x == $past(in_x)));

  p_big_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_mem1 && in_op < 3'd2 && in_size >= 2'd2 && in_count >= FULL_C) |=>
      (out_data == '0 && !out_c && !out_x && out_z));

  p_lsl_no_v_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd1) |=> !out_v);

  p_rot_keeps_x_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_op == 3'd4 || in_op == 3'd5)) |=> (!out_x_upd && out_x == $past(in_x)));

  p_rot_no_v_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op >= 3'd4) |=> !out_v);

  p_long_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_mem1 && in_size >= 2'd2) |=> (out_z == (out_data == '0)));

  p_byte_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_mem1 && in_size == '0) |=> (out_data[DATA_W-1:8] == $past(in_data[DATA_W-1:8])));

  p_mem_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mem1) |=> (out_data[DATA_W-1:16] == $past(in_data[DATA_W-1:16])));

endmodule

bind srf_unit srf_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .in_size   (in_size),
  .in_count  (in_count),
  .in_mem1   (in_mem1),
  .in_data   (in_data),
  .in_x      (in_x),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_x     (out_x),
  .out_x_upd (out_x_upd),
  .out_z     (out_z),
  .out_v     (out_v),
  .out_c     (out_c)
);

// File: tb/srf_unit_tb.sv
module srf_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [5:0]  in_count = '0;
  logic        in_mem1 = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_x = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_x, out_x_upd, out_n, out_z, out_v, out_c;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  srf_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_size(in_size), .in_count(in_count), .in_mem1(in_mem1),
    .in_data(in_data), .in_x(in_x), .out_valid(out_valid),
    .out_data(out_data), .out_x(out_x), .out_x_upd(out_x_upd),
    .out_n(out_n), .out_z(out_z), .out_v(out_v), .out_c(out_c)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected behaviour, stepped one bit at a time from the requirements.
  function automatic void model(input int op, input int size, input int cnt_in,
      input logic [31:0] d, input logic xi, input logic mem,
      output logic [31:0] r_o, output logic xo, output logic xu,
      output logic n, output logic z, output logic v, output logic c);
    int w, cnt, k;
    longint unsigned mask, top, rv, dv, nb, xx;
    w   = mem ? 16 : (size == 0 ? 8 : (size == 1 ? 16 : 32));
    cnt = mem ? 1 : cnt_in;
    mask = (64'd1 << w) - 1;
    top  = 64'd1 << (w - 1);
    dv = longint'(d) & mask;
    rv = dv; c = 0; v = 0; xu = 0; xo = xi;
    if (op <= 3) begin
      if (cnt != 0) begin
        xu = 1;
        for (int i = 0; i < cnt; i++) begin
          if (op <= 1) begin
            c  = ((rv & top) != 0);
            rv = (rv << 1) & mask;
          end else begin
            c  = rv[0];
            rv = (rv >> 1) | ((op == 2 && (dv & top) != 0) ? top : 0);
          end
        end
        if (op <= 1 && cnt >= w) c = 0;
        if (op == 0) v = (((rv ^ dv) & top) != 0);
        xo = c;
      end
    end else if (op <= 5) begin
      k = cnt % w;
      for (int i = 0; i < k; i++) begin
        if (op == 4) rv = ((rv << 1) | ((rv & top) != 0 ? 1 : 0)) & mask;
        else         rv = (rv >> 1) | (rv[0] ? top : 0);
      end
      if (k != 0) c = (op == 4) ? rv[0] : ((rv & top) != 0);
    end else begin
      k = cnt % (w + 1);
      xx = xi;
      for (int i = 0; i < k; i++) begin
        if (op == 6) begin
          nb = ((rv & top) != 0);
          rv = ((rv << 1) | xx) & mask;
        end else begin
          nb = rv & 1;
          rv = (rv >> 1) | (xx != 0 ? top : 0);
        end
        xx = nb;
      end
      if (k != 0) begin xu = 1; c = xx[0]; xo = xx[0]; end
      else c = xi;
    end
    r_o = (d & ~mask[31:0]) | rv[31:0];
    n = ((rv & top) != 0);
    z = (rv == 0);
  endfunction

  function automatic string op_req(input int op);
    case (op)
      0: return "R4";
      1: return "R3";
      2, 3: return "R5";
      4, 5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic run_case(input string req, input int op, input int size, input int cnt,
                          input logic [31:0] d, input logic xi, input logic mem);
    logic [31:0] er; logic ex, exu, en, ez, ev, ec;
    @(negedge clk);
    in_valid = 1'b1; in_op = 3'(op); in_size = 2'(size); in_count = 6'(cnt);
    in_data = d; in_x = xi; in_mem1 = mem;
    @(negedge clk);
    in_valid = 1'b0;
    model(op, size, cnt, d, xi, mem, er, ex, exu, en, ez, ev, ec);
    chk(req, "data", out_data, er);
    chk(req, "x",     {31'd0, out_x},     {31'd0, ex});
    chk(req, "x_upd", {31'd0, out_x_upd}, {31'd0, exu});
    chk("R8", "n",    {31'd0, out_n},     {31'd0, en});
    chk("R8", "z",    {31'd0, out_z},     {31'd0, ez});
    chk(req, "v",     {31'd0, out_v},     {31'd0, ev});
    chk(req, "c",     {31'd0, out_c},     {31'd0, ec});
  endtask

  task automatic t_reset();
    chk("R11", "valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R11", "data after reset", out_data, 32'd0);
  endtask

  task automatic t_valid();
    run_case("R11", 1, 2, 4, 32'h0000_00F1, 1'b0, 1'b0);
    chk("R11", "valid one cycle later", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    chk("R11", "valid drops", {31'd0, out_valid}, 32'd0);
    chk("R11", "data held", out_data, 32'h0000_0F10);
  endtask

  task automatic t_zero_shift();
    run_case("R2", 0, 2, 0, 32'h8000_0000, 1'b1, 1'b0);
    chk("R2", "operand kept", out_data, 32'h8000_0000);
    chk("R2", "x kept", {31'd0, out_x}, 32'd1);
    chk("R2", "no x update", {31'd0, out_x_upd}, 32'd0);
    run_case("R2", 3, 0, 0, 32'h0000_0081, 1'b0, 1'b0);
    chk("R2", "carry clear", {31'd0, out_c}, 32'd0);
  endtask

  task automatic t_left();
    run_case("R4", 0, 0, 1, 32'h0000_0040, 1'b0, 1'b0);
    chk("R4", "asl sign change sets v", {31'd0, out_v}, 32'd1);
    run_case("R4", 1, 0, 1, 32'h0000_0040, 1'b0, 1'b0);
    chk("R4", "lsl never sets v", {31'd0, out_v}, 32'd0);
    run_case("R3", 1, 0, 1, 32'h0000_0081, 1'b0, 1'b0);
    chk("R3", "last bit out to c", {31'd0, out_c}, 32'd1);
    chk("R3", "result", out_data, 32'h0000_0002);
    run_case("R3", 1, 1, 16, 32'h0000_8001, 1'b1, 1'b0);
    chk("R3", "count equals size clears", out_data, 32'h0000_0000);
    chk("R3", "x cleared", {31'd0, out_x}, 32'd0);
  endtask

  task automatic t_right();
    run_case("R5", 2, 1, 20, 32'h0000_8000, 1'b0, 1'b0);
    chk("R5", "asr sign fill", out_data, 32'h0000_FFFF);
    chk("R5", "asr beyond size c", {31'd0, out_c}, 32'd1);
    run_case("R5", 3, 1, 20, 32'h0000_8000, 1'b1, 1'b0);
    chk("R5", "lsr zero fill", out_data, 32'h0000_0000);
    chk("R5", "lsr beyond size c", {31'd0, out_c}, 32'd0);
    run_case("R5", 3, 0, 1, 32'h0000_0081, 1'b0, 1'b0);
    chk("R5", "lsr result", out_data, 32'h0000_0040);
    chk("R5", "lsr x", {31'd0, out_x}, 32'd1);
  endtask

  task automatic t_rot();
    run_case("R6", 4, 0, 8, 32'h0000_0081, 1'b1, 1'b0);
    chk("R6", "rol by size is identity", out_data, 32'h0000_0081);
    chk("R6", "rol zero reduced c", {31'd0, out_c}, 32'd0);
    run_case("R6", 5, 0, 1, 32'h0000_0001, 1'b0, 1'b0);
    chk("R6", "ror result", out_data, 32'h0000_0080);
    chk("R6", "ror c from top", {31'd0, out_c}, 32'd1);
  endtask

  task automatic t_rox();
    run_case("R7", 6, 0, 9, 32'h0000_0080, 1'b1, 1'b0);
    chk("R7", "ring identity", out_data, 32'h0000_0080);
    chk("R7", "x copied to c", {31'd0, out_c}, 32'd1);
    chk("R7", "x not written", {31'd0, out_x_upd}, 32'd0);
    run_case("R7", 6, 0, 1, 32'h0000_0080, 1'b0, 1'b0);
    chk("R7", "top into x", {31'd0, out_x}, 32'd1);
    chk("R7", "zero result", {31'd0, out_z}, 32'd1);
    run_case("R7", 7, 0, 1, 32'h0000_0001, 1'b1, 1'b0);
    chk("R7", "x enters top", out_data, 32'h0000_0080);
  endtask

  task automatic t_sizes();
    run_case("R9", 1, 0, 4, 32'hA5A5_1234, 1'b0, 1'b0);
    chk("R9", "byte upper pass", out_data, 32'hA5A5_1240);
    run_case("R1", 3, 0, 1, 32'h0000_0002, 1'b0, 1'b0);
    chk("R1", "code 3 logical right", out_data, 32'h0000_0001);
    run_case("R1", 1, 3, 1, 32'h8000_0000, 1'b0, 1'b0);
    chk("R1", "size 3 acts as long", out_data, 32'h0000_0000);
    chk("R1", "long carry", {31'd0, out_c}, 32'd1);
  endtask

  task automatic t_mem();
    run_case("R10", 2, 0, 40, 32'h1234_8001, 1'b0, 1'b1);
    chk("R10", "word by one", out_data, 32'h1234_C000);
    chk("R10", "carry", {31'd0, out_c}, 32'd1);
  endtask

  task automatic t_sweep();
    int cnts[13] = '{0, 1, 2, 7, 8, 9, 15, 16, 17, 31, 32, 33, 63};
    logic [31:0] lfsr = 32'hC0DE_1357;
    for (int op = 0; op < 8; op++)
      for (int sz = 0; sz < 3; sz++)
        for (int ci = 0; ci < 13; ci++) begin
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          run_case(op_req(op), op, sz, cnts[ci], lfsr, lfsr[3], 1'b0);
        end
    for (int op = 0; op < 8; op++)
      run_case("R10", op, 0, 5, 32'hF00D_8421 ^ 32'(op), 1'(op), 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_valid();
    t_zero_shift();
    t_left();
    t_right();
    t_rot();
    t_rox();
    t_sizes();
    t_mem();
    t_sweep();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule